// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block lets an external host read and write a small bank of 8-bit configuration registers over three pins: a serial clock, an active-low select and one half-duplex data line. The three pins are brought into the core clock domain through synchronisers. Serial clock edges are detected there, so all state runs on `clk_i`, and the core clock must run several times faster than the serial clock.

Each transaction opens with an instruction byte that gives the direction and a 7-bit start address. One or more data bytes follow. After each data byte the address steps by itself: downward when bytes travel most-significant bit first, and upward when they travel least-significant bit first. Register 0 controls the port. Bit 6 of register 0 selects the bit order, and bit 7 of register 0 lets the data pin drive read data. Every register is visible on `regs_o`, and a one-cycle strobe per register marks each write.

Top module: `spi3_cfg_port`

## Requirements
- R1: After the select falls, the first eight rising serial clock edges shift in the instruction byte. Instruction bit 7 = 1 means read and 0 means write. Bits 6..0 give the start address. Every later rising edge belongs to the data phase.
- R2: Raising the select and then lowering it again returns the port to the start of the instruction phase. Any partly shifted byte is dropped, and no register changes because of it.
- R3: The data line is sampled on rising serial clock edges and driven on falling edges. The first read data bit is on the pin after the falling edge that follows the eighth instruction bit.
- R4: While the select is high, `sdio_oe_o` is 0 (pin released).
- R5: A written register holds its new value once the last bit of its data byte is sampled, before the select rises. `wr_stb_o` pulses exactly once, on that register's bit, for each accepted write.
- R6: For each extra data byte, the address steps by −1 in MSB-first order and by +1 in LSB-first order, modulo 128.
- R7: Register 0 bit 6 = 1 selects LSB-first order for both the instruction and the data bytes, and 0 selects MSB-first order. A change applies from the next byte boundary.
- R8: When register 0 bit 7 is 0, read data is not driven (`sdio_oe_o` stays 0). When it is 1, the pin is driven throughout the read data phase.
- R9: Writes to addresses at or above NUM_REGS are dropped, with no register change and no strobe. Reads from those addresses return 0x00.
- R10: After reset all registers are 0x00 (MSB-first order, readback off), no strobe is active and the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, several times faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host (idles low) |
| cs_ni | input | 1 | Active-low transaction select |
| sdio_i | input | 1 | Data line as seen at the pad input |
| sdio_o | output | 1 | Data line value to drive |
| sdio_oe_o | output | 1 | Pad driver enable for the data line |
| regs_o | output | NUM_REGS*8 | All registers, register i at bits [8i+7:8i] |
| wr_stb_o | output | NUM_REGS | One-cycle write strobe per register |

## Verification
Two things can happen at the same byte boundary: a write to register 0 can change the bit order, and the address must step. The step has to use the order of the byte just finished, while the next byte uses the new order. The bench provokes this with multi-byte transfers that start or wrap onto register 0 in both orders. Its behavioural model takes the order afresh at every byte, and the register values and read data it predicts expose any mismatch. In the same way, a read fetch at the end of the instruction meets the first driving falling edge, and the bench judges this by the value sampled before the first data rising edge.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int ADDR_W        = 7;
  localparam int BYTE_W        = 8;
  localparam int CTRL_RDEN_BIT = 7;
  localparam int CTRL_LSB_BIT  = 6;

  typedef enum logic {
    PH_INSTR = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else             stg[s] <= stg[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_s_i,
  input  logic              sdi_s_i,
  input  logic              lsb_first_i,
  input  logic              rden_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sdio_o,
  output logic              sdio_oe_o
);
  logic              sclk_d;
  logic              rise, fall, byte_done;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] sh_q, nxt_sh, tx_q;
  logic [ADDR_W-1:0] addr_q, addr_step;
  phase_e            phase_q;
  logic              rw_q, out_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s_i;
  end

  assign rise      = sclk_s_i & ~sclk_d & ~cs_s_i;
  assign fall      = ~sclk_s_i & sclk_d & ~cs_s_i;
  assign byte_done = rise && (bit_cnt == 3'd7);
  assign nxt_sh    = lsb_first_i ? {sdi_s_i, sh_q[BYTE_W-1:1]}
                                 : {sh_q[BYTE_W-2:0], sdi_s_i};
  // step follows the order of the byte just completed
  assign addr_step = lsb_first_i ? addr_q + 1'b1 : addr_q - 1'b1;
  assign rd_addr_o = (phase_q == PH_INSTR) ? nxt_sh[ADDR_W-1:0] : addr_step;

  assign wr_en_o   = byte_done && (phase_q == PH_DATA) && !rw_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = nxt_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      phase_q <= PH_INSTR;
      rw_q    <= 1'b0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else if (cs_s_i) begin
      bit_cnt <= '0;
      phase_q <= PH_INSTR;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        sh_q    <= nxt_sh;
      end
      if (byte_done) begin
        if (phase_q == PH_INSTR) begin
          phase_q <= PH_DATA;
          rw_q    <= nxt_sh[BYTE_W-1];
          addr_q  <= nxt_sh[ADDR_W-1:0];
          if (nxt_sh[BYTE_W-1]) tx_q <= rd_data_i;
        end else begin
          addr_q <= addr_step;
          if (rw_q) tx_q <= rd_data_i;
        end
      end
      if (fall && phase_q == PH_DATA && rw_q) begin
        out_q <= lsb_first_i ? tx_q[0] : tx_q[BYTE_W-1];
        tx_q  <= lsb_first_i ? {1'b0, tx_q[BYTE_W-1:1]} : {tx_q[BYTE_W-2:0], 1'b0};
        oe_q  <= rden_i;
      end
    end
  end

  assign sdio_o    = out_q;
  assign sdio_oe_o = oe_q;

  p_oe_off_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_i |=> !sdio_oe_o);
  p_oe_needs_rden_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> rden_i);
  p_instr_to_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && phase_q == PH_INSTR) |=> (phase_q == PH_DATA && rw_q == $past(nxt_sh[BYTE_W-1])));
  p_addr_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && phase_q == PH_DATA && !lsb_first_i) |=> addr_q == ADDR_W'($past(addr_q) - 1'b1));
  p_addr_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && phase_q == PH_DATA && lsb_first_i) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));
endmodule

// File: rtl/spi3_regfile.sv
module spi3_regfile
  import spi3_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [BYTE_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [BYTE_W-1:0]          rd_data_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o,
  output logic [NUM_REGS-1:0]        wr_stb_o
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [BYTE_W-1:0] mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem[i]      <= '0;
        wr_stb_o[i] <= 1'b0;
      end else begin
        wr_stb_o[i] <= hit;
        if (hit) mem[i] <= wr_data_i;
      end
    end

    assign regs_o[i*BYTE_W +: BYTE_W] = mem[i];

    p_reg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(mem[i]) |-> wr_stb_o[i]);
  end

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_addr_i) < NUM_REGS) rd_data_o = mem[rd_addr_i[IDX_W-1:0]];
  end

  p_stb_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_stb_o));
endmodule

// File: rtl/spi3_cfg_port.sv
module spi3_cfg_port
  import spi3_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       cs_ni,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o,
  output logic [NUM_REGS-1:0]        wr_stb_o
);
  logic [2:0]        pins_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  spi3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdio_i, cs_ni, sclk_i}),
    .q_o    (pins_s)
  );

  spi3_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (pins_s[0]),
    .cs_s_i      (pins_s[1]),
    .sdi_s_i     (pins_s[2]),
    .lsb_first_i (regs_o[CTRL_LSB_BIT]),
    .rden_i      (regs_o[CTRL_RDEN_BIT]),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .sdio_o      (sdio_o),
    .sdio_oe_o   (sdio_oe_o)
  );

  spi3_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (regs_o),
    .wr_stb_o  (wr_stb_o)
  );
endmodule

// File: tb/spi3_cfg_port_test.sv
module spi3_cfg_port_test;
  localparam int NR   = 8;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, oe;
  logic [NR*8-1:0] regs;
  logic [NR-1:0]   stb;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] exp_r [NR];
  int exp_stb [NR];
  int got_stb [NR];
  int cs_hi = 0;
  logic [7:0] wbuf [4];

  always #2 clk = ~clk;

  spi3_cfg_port #(.NUM_REGS(NR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdio_i(sdi),
    .sdio_o(sdo), .sdio_oe_o(oe), .regs_o(regs), .wr_stb_o(stb)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NR*8-1:0] exp_vec();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = exp_r[i];
    return v;
  endfunction

  // per-clock monitor: pin released while select is high, strobe tally
  always @(negedge clk) begin
    if (rst_n) begin
      cs_hi = cs_n ? cs_hi + 1 : 0;
      if (cs_hi >= 4) chk("R4", {63'd0, oe}, 64'd0, "oe with select high");
      for (int i = 0; i < NR; i++) if (stb[i]) got_stb[i]++;
    end
  end

  task automatic send_bit(input logic b);
    sdi = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic xfer(input string req, input logic rd, input logic [6:0] a, input int n);
    logic [7:0] ins, eb, got;
    logic [6:0] ad;
    logic lsb, en, oe_ok;
    ins = {rd, a};
    lsb = exp_r[0][6];
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int j = 0; j < 8; j++) send_bit(ins[lsb ? j : 7 - j]);
    ad = a;
    for (int k = 0; k < n; k++) begin
      lsb = exp_r[0][6];
      en  = exp_r[0][7];
      eb  = (int'(ad) < NR) ? exp_r[ad] : 8'h00;
      got = '0;
      oe_ok = 1'b1;
      for (int j = 0; j < 8; j++) begin
        sdi = rd ? 1'b0 : wbuf[k][lsb ? j : 7 - j];
        wait_clk(HALF);
        if (rd) begin
          got[lsb ? j : 7 - j] = sdo;
          if (oe !== en) oe_ok = 1'b0;
        end
        sclk = 1'b1;
        wait_clk(HALF);
        if (j == 7 && !rd) begin
          if (int'(ad) < NR) begin
            exp_r[ad] = wbuf[k];
            exp_stb[ad]++;
          end
          chk(req, regs, exp_vec(), "regs after byte");
        end
        sclk = 1'b0;
      end
      if (rd) begin
        chk("R8", {63'd0, oe_ok}, 64'd1, "oe during read byte");
        if (en) chk(req, {56'd0, got}, {56'd0, eb}, "read byte");
      end
      ad = lsb ? ad + 7'd1 : ad - 7'd1;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic wr1(input string req, input logic [6:0] a, input logic [7:0] v);
    wbuf[0] = v;
    xfer(req, 1'b0, a, 1);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin
      exp_r[i] = '0; exp_stb[i] = 0; got_stb[i] = 0;
    end
    wait_clk(5);
    // R10 reset state
    chk("R10", regs, '0, "regs in reset");
    chk("R10", {63'd0, oe}, 64'd0, "oe in reset");
    rst_n = 1'b1;
    wait_clk(5);
    chk("R10", {56'd0, stb}, 64'd0, "strobes after reset");

    // R1 R5 single write, MSB-first
    wr1("R1", 7'd1, 8'hA5);
    // R6 MSB-first multi-byte write steps down: 3,2,1
    wbuf[0] = 8'h33; wbuf[1] = 8'h22; wbuf[2] = 8'h5A;
    xfer("R6", 1'b0, 7'd3, 3);
    // R8 read with readback off: pin must stay released
    xfer("R8", 1'b1, 7'd1, 1);
    // enable readback, keep MSB-first
    wr1("R8", 7'd0, 8'h80);
    // R3 R6 multi-byte read 3,2,1,0
    xfer("R3", 1'b1, 7'd3, 4);
    // R9 read wraps 1,0,127 (undefined -> 0)
    xfer("R9", 1'b1, 7'd1, 3);
    // R9 write to undefined address dropped
    wr1("R9", 7'h40, 8'hFF);
    // R2 abandoned partial byte then clean write
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int j = 0; j < 5; j++) send_bit(1'b1);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
    chk("R2", regs, exp_vec(), "regs after abort");
    wr1("R2", 7'd4, 8'h3C);
    // R7 switch to LSB-first (this byte still MSB-first)
    wr1("R7", 7'd0, 8'hC0);
    // R6 R7 LSB-first multi-byte write steps up: 5,6,7
    wbuf[0] = 8'h01; wbuf[1] = 8'h82; wbuf[2] = 8'h4E;
    xfer("R7", 1'b0, 7'd5, 3);
    // R7 LSB-first read back 5,6,7,0
    xfer("R7", 1'b1, 7'd5, 4);
    // R6 wrap upward: 127 (dropped), then 0
    wbuf[0] = 8'h99; wbuf[1] = 8'hC1;
    xfer("R6", 1'b0, 7'h7F, 2);
    // R7 order change lands at a byte boundary: reg0 -> MSB-first, then step uses old order
    wbuf[0] = 8'h80; wbuf[1] = 8'h77; wbuf[2] = 8'h66;
    xfer("R7", 1'b0, 7'd0, 3);
    xfer("R7", 1'b1, 7'd2, 3);

    // R5 one strobe per accepted write
    for (int i = 0; i < NR; i++) chk("R5", 64'(got_stb[i]), 64'(exp_stb[i]), $sformatf("strobe count reg%0d", i));
    chk("R4", {63'd0, oe}, 64'd0, "oe at end");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule